// File: doc/BRIEF.md
# SPI Receive Status and Error Flags

This block holds the receive-side status of a serial peripheral port as seen by a CPU over a simple single-cycle register bus. A shift-register core hands it a one-cycle "byte received" pulse with the byte, and a "mode fault detected" level. The block keeps the receive data register, a receiver-full flag, an overflow flag and a mode-fault flag. It drives a receive interrupt and one combined error interrupt.

The flags are cleared by CPU access sequences rather than by direct writes. For each flag, a status read that sees the flag set "arms" it. The next data read then clears an armed full or overflow flag, and the next control write clears an armed mode-fault flag. Any other bus access disarms all flags. While overflow is pending, incoming bytes are dropped without touching the full flag or the data register. Software therefore has to service the overflow before reception resumes.

Register map (2-bit address, read data combinational in the access cycle): address 0 is control, address 1 is status, address 2 is data, and address 3 reads as zero. Control bit 0 is the receive-interrupt enable, bit 1 the error-interrupt enable and bit 2 the mode-fault enable. Status bit 0 is full, bit 1 overflow and bit 2 mode fault. All other bits read as zero.

Top module: `spi_rx_status`

## Requirements
- R1: After reset, all three flags, the armed bits, the data register and all three enables are 0, and both interrupts are low.
- R2: A byte pulse while full and overflow are both clear stores the byte in the data register and sets full, visible from the next cycle.
- R3: A byte pulse while full is set and overflow is clear sets overflow, and the data register keeps the earlier byte.
- R4: A byte pulse while overflow is set leaves full unchanged and the data register unchanged; that byte is lost.
- R5: A status read (address 1) that sees full set, followed directly by a data read (address 2), clears full. A data read with full not armed leaves full set.
- R6: Overflow clears only on a data read that directly follows a status read which saw overflow set. If overflow rose after that status read, the data read clears full but leaves overflow set.
- R7: The mode-fault flag is set by the mode-fault input only while control bit 2 is 1. With that bit at 0 the flag never becomes set.
- R8: The mode-fault flag clears on a control write (address 0) that directly follows a status read which saw it set. A new fault in the same cycle wins over the clear.
- R9: The error interrupt is high exactly when control bit 1 is 1 and overflow or mode fault is set.
- R10: The receive interrupt is high exactly when control bit 0 is 1 and full is set.
- R11: A byte pulse in the same cycle as a clearing data read lands as if the register were empty. Full stays set, the data register takes the new byte, and overflow is not set.
- R12: Any bus access other than a status read, including a control read, a data write or an access to address 3, disarms all flags. A following data read then clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | One-cycle pulse: a byte has been shifted in |
| rx_byte_i | input | DATA_W | Received byte, valid with rx_valid_i |
| mode_fault_i | input | 1 | Mode fault detected by the core |
| reg_req_i | input | 1 | Bus access this cycle |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | REG_W | Write data |
| reg_rdata_o | output | REG_W | Read data, combinational in the access cycle |
| rx_irq_o | output | 1 | Receive interrupt |
| err_irq_o | output | 1 | Combined overflow / mode-fault interrupt |

## Verification
A wrong armed bit shows up on the data read that follows it. Full or overflow survives when it should clear, or vanishes when it should stay, and the next status read reports it within two cycles. A wrong flag value shows up at once on the interrupt outputs whenever the matching enable is on. A corrupted data register shows up on the next data read, because overflow and dropped bytes must leave the earlier byte visible. The bench runs a cycle-accurate reference model alongside random bus and byte traffic, and compares every read value and both interrupts every cycle. A divergence is therefore reported in the cycle it first appears at a port.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  typedef struct packed {
    logic mf_en;
    logic err_ie;
    logic rx_ie;
  } ctrl_t;

  typedef struct packed {
    logic mf;
    logic ovf;
    logic full;
  } flags_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int FLAG_W = $bits(flags_t);
endpackage

// File: rtl/spi_rx_ctrl_reg.sv
module spi_rx_ctrl_reg
  import spi_rx_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output ctrl_t            ctrl_o
);
  ctrl_t ctrl_q;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[REG_W-1:CTRL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (wr_i) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/spi_rx_clear_seq.sv
// Per-flag armed bit: status read arms, matching strobe clears, other access disarms.
module spi_rx_clear_seq #(
  parameter int NFLAG = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stat_rd_i,
  input  logic             any_acc_i,
  input  logic [NFLAG-1:0] flags_i,
  input  logic [NFLAG-1:0] strobe_i,
  output logic [NFLAG-1:0] clr_o
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_arm
    logic arm_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        arm_q <= 1'b0;
      else if (stat_rd_i) arm_q <= flags_i[i];
      else if (any_acc_i) arm_q <= 1'b0;
    end
    assign clr_o[i] = arm_q & strobe_i[i];
  end
endmodule

// File: rtl/spi_rx_flags.sv
module spi_rx_flags
  import spi_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              mode_fault_i,
  input  logic              mf_en_i,
  input  flags_t            clr_i,
  output flags_t            flags_o,
  output logic [DATA_W-1:0] data_o
);
  flags_t            flags_q;
  logic [DATA_W-1:0] data_q;
  logic              full_n, ovf_n, land, spill;

  // clear takes effect before a same-cycle arrival is judged
  always_comb begin
    full_n = flags_q.full & ~clr_i.full;
    ovf_n  = flags_q.ovf  & ~clr_i.ovf;
    land   = rx_valid_i & ~ovf_n & ~full_n;
    spill  = rx_valid_i & ~ovf_n &  full_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      data_q  <= '0;
    end else begin
      flags_q.full <= full_n | land;
      flags_q.ovf  <= ovf_n | spill;
      flags_q.mf   <= (flags_q.mf & ~clr_i.mf) | (mode_fault_i & mf_en_i);
      if (land) data_q <= rx_byte_i;
    end
  end

  assign flags_o = flags_q;
  assign data_o  = data_q;
endmodule

// File: rtl/spi_rx_status.sv
module spi_rx_status
  import spi_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              mode_fault_i,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              rx_irq_o,
  output logic              err_irq_o
);
  logic stat_rd, data_rd, ctrl_wr, rd;
  ctrl_t             ctrl_q;
  flags_t            flags_q, clr, strobe;
  logic [DATA_W-1:0] data_q;

  assign rd      = reg_req_i & ~reg_we_i;
  assign stat_rd = rd & (reg_addr_i == ADDR_STAT);
  assign data_rd = rd & (reg_addr_i == ADDR_DATA);
  assign ctrl_wr = reg_req_i & reg_we_i & (reg_addr_i == ADDR_CTRL);

  always_comb begin
    strobe      = '0;
    strobe.full = data_rd;
    strobe.ovf  = data_rd;
    strobe.mf   = ctrl_wr;
  end

  spi_rx_ctrl_reg #(.REG_W(REG_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ctrl_wr),
    .wdata_i (reg_wdata_i),
    .ctrl_o  (ctrl_q)
  );

  spi_rx_clear_seq #(.NFLAG(FLAG_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stat_rd_i (stat_rd),
    .any_acc_i (reg_req_i),
    .flags_i   (flags_q),
    .strobe_i  (strobe),
    .clr_o     (clr)
  );

  spi_rx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_valid_i   (rx_valid_i),
    .rx_byte_i    (rx_byte_i),
    .mode_fault_i (mode_fault_i),
    .mf_en_i      (ctrl_q.mf_en),
    .clr_i        (clr),
    .flags_o      (flags_q),
    .data_o       (data_q)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (rd) begin
      unique case (reg_addr_i)
        ADDR_CTRL: reg_rdata_o = REG_W'(ctrl_q);
        ADDR_STAT: reg_rdata_o = REG_W'(flags_q);
        ADDR_DATA: reg_rdata_o = REG_W'(data_q);
        default:   reg_rdata_o = '0;
      endcase
    end
  end

  assign rx_irq_o  = flags_q.full & ctrl_q.rx_ie;
  assign err_irq_o = (flags_q.ovf | flags_q.mf) & ctrl_q.err_ie;
endmodule

// File: rtl/spi_rx_status_chk.sv
module spi_rx_status_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_valid_i,
  input logic [DATA_W-1:0] rx_byte_i,
  input logic              mode_fault_i,
  input logic              reg_req_i,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic              rx_irq_o,
  input logic              err_irq_o,
  input logic              full_i,
  input logic              ovf_i,
  input logic              mf_i,
  input logic              mf_en_i,
  input logic [DATA_W-1:0] data_i
);
  logic drd;
  assign drd = reg_req_i & ~reg_we_i & (reg_addr_i == 2'd2);

  AST_FILL_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !full_i && !ovf_i) |=> (full_i && data_i == $past(rx_byte_i))); // R2

  AST_SPILL_KEEPS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && full_i && !ovf_i && !drd) |=> (ovf_i && $stable(data_i))); // R3

  AST_OVF_BLOCKS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && ovf_i && !full_i && !drd) |=> (!full_i && $stable(data_i))); // R4

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && !drd) |=> ovf_i); // R6

  AST_MF_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mf_en_i && !mf_i) |=> !mf_i); // R7

  AST_RX_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_i |-> !rx_irq_o); // R10

  AST_ERR_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_i && !mf_i) |-> !err_irq_o); // R9

  logic unused_chk;
  assign unused_chk = mode_fault_i;
endmodule

bind spi_rx_status spi_rx_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rx_valid_i   (rx_valid_i),
  .rx_byte_i    (rx_byte_i),
  .mode_fault_i (mode_fault_i),
  .reg_req_i    (reg_req_i),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .rx_irq_o     (rx_irq_o),
  .err_irq_o    (err_irq_o),
  .full_i       (flags_q.full),
  .ovf_i        (flags_q.ovf),
  .mf_i         (flags_q.mf),
  .mf_en_i      (ctrl_q.mf_en),
  .data_i       (data_q)
);

// File: tb/spi_rx_status_tb.sv
`timescale 1ns/1ps
module spi_rx_status_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0, mode_fault = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       req = 1'b0, we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rx_irq, err_irq;

  int total = 0, bad = 0, ncyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_rx_status u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_valid_i(rx_valid), .rx_byte_i(rx_byte), .mode_fault_i(mode_fault),
    .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .rx_irq_o(rx_irq), .err_irq_o(err_irq)
  );

  // reference model
  logic m_full, m_ovf, m_mf, a_full, a_ovf, a_mf, m_rxie, m_errie, m_mfen;
  logic [7:0] m_data;

  task automatic model_reset();
    {m_full, m_ovf, m_mf, a_full, a_ovf, a_mf, m_rxie, m_errie, m_mfen} = '0;
    m_data = '0;
  endtask

  function automatic logic [7:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0:    return {5'b0, m_mfen, m_errie, m_rxie};
      2'd1:    return {5'b0, m_mf, m_ovf, m_full};
      2'd2:    return m_data;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_rx_irq();
    return m_full & m_rxie;
  endfunction

  function automatic logic exp_err_irq();
    return (m_ovf | m_mf) & m_errie;
  endfunction

  task automatic model_step(logic q, logic w, logic [1:0] a, logic [7:0] wd,
                            logic v, logic [7:0] b, logic mfi);
    logic srd, drd, cwr, f, o, m;
    srd = q & ~w & (a == 2'd1);
    drd = q & ~w & (a == 2'd2);
    cwr = q & w & (a == 2'd0);
    f = m_full & ~(drd & a_full);
    o = m_ovf & ~(drd & a_ovf);
    m = (m_mf & ~(cwr & a_mf)) | (mfi & m_mfen);
    if (v) begin
      if (o) ;
      else if (f) o = 1'b1;
      else begin f = 1'b1; m_data = b; end
    end
    if (srd) {a_mf, a_ovf, a_full} = {m_mf, m_ovf, m_full};
    else if (q) {a_mf, a_ovf, a_full} = 3'b000;
    if (cwr) {m_mfen, m_errie, m_rxie} = wd[2:0];
    m_full = f; m_ovf = o; m_mf = m;
  endtask

  task automatic chk(string req_s, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req_s, act, exp);
    end
  endtask

  task automatic cyc(logic q, logic w, logic [1:0] a, logic [7:0] wd,
                     logic v, logic [7:0] b, logic mfi, output logic [7:0] rd);
    @(negedge clk);
    req = q; we = w; addr = a; wdata = wd; rx_valid = v; rx_byte = b; mode_fault = mfi;
    #1;
    rd = rdata;
    if (q && !w) chk("R5 read value", rd, exp_rd(a));
    @(posedge clk);
    model_step(q, w, a, wd, v, b, mfi);
    #1;
    chk("R10 rx irq", rx_irq, exp_rx_irq());
    chk("R9 err irq", err_irq, exp_err_irq());
  endtask

  logic [7:0] r;
  task automatic idle();              cyc(0, 0, 0, 0, 0, 0, 0, r); endtask
  task automatic wr_ctrl(logic [7:0] v); cyc(1, 1, 0, v, 0, 0, 0, r); endtask
  task automatic rd_reg(logic [1:0] a);  cyc(1, 0, a, 0, 0, 0, 0, r); endtask
  task automatic push(logic [7:0] b);    cyc(0, 0, 0, 0, 1, b, 0, r); endtask
  task automatic fault();                cyc(0, 0, 0, 0, 0, 0, 1, r); endtask

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<150000", ncyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd_reg(1); chk("R1 status", r, 8'h00);
    rd_reg(0); chk("R1 ctrl", r, 8'h00);
    rd_reg(2); chk("R1 data", r, 8'h00);
    chk("R1 irqs", {rx_irq, err_irq}, 2'b00);

    wr_ctrl(8'h07);
    push(8'hA5);
    chk("R10 rx irq on full", rx_irq, 1'b1);
    rd_reg(1); chk("R2 full set", r, 8'h01);       // arms full
    push(8'h3C);                                    // overflow after status read
    chk("R9 err irq on ovf", err_irq, 1'b1);
    rd_reg(2); chk("R3 earlier byte kept", r, 8'hA5);
    rd_reg(1); chk("R6 ovf survives late set", r, 8'h02);  // arms ovf
    push(8'h77);
    rd_reg(1); chk("R4 dropped byte leaves full clear", r, 8'h02);
    rd_reg(2); chk("R4 data unchanged", r, 8'hA5);
    rd_reg(1); chk("R6 ovf cleared by armed read", r, 8'h00);

    // R5 data read without arming
    push(8'h11);
    rd_reg(2); chk("R5 read value unarmed", r, 8'h11);
    rd_reg(1); chk("R5 full kept without arm", r, 8'h01);
    // R12 intervening access disarms
    rd_reg(0);
    rd_reg(2);
    rd_reg(1); chk("R12 disarmed by ctrl read", r, 8'h01);
    cyc(1, 1, 2'd3, 8'hFF, 0, 0, 0, r);            // write to address 3
    rd_reg(2);
    rd_reg(1); chk("R12 disarmed by addr3 write", r, 8'h01);
    rd_reg(2);
    rd_reg(1); chk("R5 full cleared", r, 8'h00);

    // R11 arrival with clearing read
    push(8'h22);
    rd_reg(1);
    cyc(1, 0, 2'd2, 0, 1, 8'h33, 0, r); chk("R11 read returns old", r, 8'h22);
    rd_reg(1); chk("R11 full set ovf clear", r, 8'h01);
    rd_reg(2); chk("R11 new byte landed", r, 8'h33);
    rd_reg(1); rd_reg(2);

    // R7 / R8 mode fault
    wr_ctrl(8'h03);
    fault();
    rd_reg(1); chk("R7 gated off", r, 8'h00);
    wr_ctrl(8'h07);
    fault();
    rd_reg(1); chk("R7 set when enabled", r, 8'h04);
    chk("R9 err irq on mf", err_irq, 1'b1);
    rd_reg(2);
    wr_ctrl(8'h07);
    rd_reg(1); chk("R8 not armed", r, 8'h04);
    cyc(1, 1, 2'd0, 8'h07, 0, 0, 1, r);             // armed clear with new fault
    rd_reg(1); chk("R8 fault wins", r, 8'h04);
    wr_ctrl(8'h05);
    rd_reg(1); chk("R8 cleared", r, 8'h00);
    chk("R9 err irq low", err_irq, 1'b0);
    // R9 enable off with flag set
    push(8'h01); push(8'h02);
    chk("R9 err irq disabled", err_irq, 1'b0);
    wr_ctrl(8'h00);
    chk("R10 rx irq disabled", rx_irq, 1'b0);

    // random traffic against model
    for (int i = 0; i < 6000; i++) begin
      logic q, w, v, mfi;
      logic [1:0] a;
      q   = ($urandom % 100) < 40;
      w   = ($urandom % 100) < 25;
      a   = 2'($urandom);
      v   = ($urandom % 100) < 25;
      mfi = ($urandom % 100) < 4;
      cyc(q, w, a, 8'($urandom), v, 8'($urandom), mfi, r);
    end
    idle();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule